// File: doc/BRIEF.md
# Serial ADC Frame Capture Controller

This block drives a 12-bit serial-output analog-to-digital converter and turns its bit stream into parallel samples. From a 100 MHz system clock it generates an active-low chip-select and a serial clock with a period of six system clocks. It runs conversions back to back, one frame every 114 system clocks. In each frame chip-select stays low for 17 serial clock periods. The serial data line is sampled once at the chip-select falling edge and then on each following rising edge of the serial clock. At the falling serial clock edge of the 17th period, the twelve data bits are placed on a parallel output together with a one-cycle valid pulse.

Everything runs in the system clock domain. The serial clock is an ordinary registered-state output and is never used as a clock internally. A three-state machine holds the frame sequence:
- `ST_GAP`: chip-select high, serial clock high.
- `ST_HIGH`: chip-select low, serial clock high.
- `ST_LOW`: chip-select low, serial clock low.

The state moves through these transitions:
- GAP→HIGH when the inter-frame gap has run out. This is the frame start and the first sample point.
- HIGH→LOW when a high half-period ends.
- LOW→HIGH when a low half-period ends and frame periods remain. This is a rising edge and a sample point.
- LOW→GAP when the last low half-period ends.

The converter sends four leading bits and then twelve data bits, MSB first. The first four sample points and the last one are discarded.

Top module: `sadc_frame_capture`

## Requirements
- R1: While `rst` is high, and from the first clock edge with `rst` high, `adc_cs_n` = 1, `adc_sclk` = 1, `sample` = 0 and `sample_valid` = 0. This holds even when reset arrives in the middle of a frame.
- R2: While `adc_cs_n` is low, `adc_sclk` has a period of 6 system clocks: high for 3, then low for 3. Counting from the first low chip-select clock as index 0, rising edges fall at indices 6k and falling edges at 6k+3.
- R3: Each frame holds `adc_cs_n` low for exactly 102 consecutive clocks. After `rst` is released, chip-select first reads low on the 12th clock edge.
- R4: Chip-select falling edges are 114 clocks apart. `adc_sclk` stays high on every clock in which `adc_cs_n` is high.
- R5: `adc_cs_n` falls while `adc_sclk` is high. There are exactly 16 rising `adc_sclk` edges while `adc_cs_n` is low. The sample points are the chip-select falling edge (point 0) and those 16 rising edges (points 1 to 16).
- R6: The values of `adc_sdata` at sample points 4 through 15 form `sample`, MSB first: point 4 goes to bit 11 and point 15 goes to bit 0.
- R7: The value of `adc_sdata` at sample points 0 to 3 and at point 16 has no effect on `sample`.
- R8: `sample_valid` is high for exactly one clock per frame. That clock is the first low `adc_sclk` clock of the 17th period (index 99 after the chip-select fall). `sample` shows the new value in that same clock.
- R9: `sample` changes only in clocks where `sample_valid` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 100 MHz |
| rst | input | 1 | Synchronous active-high reset |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip-select to the converter |
| adc_sclk | output | 1 | Serial clock to the converter |
| sample | output | 12 | Last captured 12-bit conversion result |
| sample_valid | output | 1 | One-clock pulse marking a new `sample` |

## Verification
A half-period or gap counter that is off by one shows up within a single frame, in about one microsecond. It appears as a chip-select low time other than 102 clocks, a frame spacing other than 114, or a rising serial clock edge away from a multiple of six. A wrong state decode shows at once as a low serial clock during the gap, or as chip-select falling on a low clock. A mistake in the window that keeps bits shows at the next valid pulse, as a result that is rotated by one place or polluted by the ones the bench drives on the ignored sample points.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    // Frame sequencer states
    typedef enum logic [1:0] {
        ST_GAP  = 2'd0,   // chip-select high between frames, clock idles high
        ST_HIGH = 2'd1,   // chip-select low, serial clock high half
        ST_LOW  = 2'd2    // chip-select low, serial clock low half
    } sadc_state_e;

endpackage

// File: rtl/sadc_frame_fsm.sv
module sadc_frame_fsm
    import sadc_pkg::*;
#(
    parameter int HALF_CLKS   = 3,
    parameter int FRAME_SCLKS = 17,
    parameter int GAP_CLKS    = 12,
    parameter int KEEP_POINTS = 16
) (
    input  logic clk,
    input  logic rst,
    output logic cs_n,
    output logic sclk,
    output logic shift_en,
    output logic latch_en
);

    localparam int TMAX = (GAP_CLKS > HALF_CLKS) ? GAP_CLKS : HALF_CLKS;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int BW   = $clog2(FRAME_SCLKS + 1);
    localparam logic [TW-1:0] HALF_LAST = TW'(HALF_CLKS - 1);
    localparam logic [TW-1:0] GAP_LAST  = TW'(GAP_CLKS - 1);
    localparam logic [BW-1:0] BIT_LAST  = BW'(FRAME_SCLKS - 1);
    localparam logic [BW-1:0] KEEP_LAST = BW'(KEEP_POINTS - 1);

    sadc_state_e state, nxt;
    logic [TW-1:0] tick;
    logic [BW-1:0] bidx;
    logic          tick_done;

    assign tick_done = (state == ST_GAP) ? (tick == GAP_LAST) : (tick == HALF_LAST);

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_GAP:  nxt = tick_done ? ST_HIGH : ST_GAP;
            ST_HIGH: nxt = tick_done ? ST_LOW  : ST_HIGH;
            ST_LOW:  begin
                if (tick_done) nxt = (bidx == BIT_LAST) ? ST_GAP : ST_HIGH;
                else           nxt = ST_LOW;
            end
            default: nxt = ST_GAP;
        endcase
    end

    // State register with its phase and period counters
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_GAP;
            tick  <= '0;
            bidx  <= '0;
        end else begin
            state <= nxt;
            tick  <= (nxt != state) ? '0 : tick + 1'b1;
            if (state == ST_GAP)
                bidx <= '0;
            else if (state == ST_LOW && tick_done)
                bidx <= bidx + 1'b1;
        end
    end

    // Outputs and strobes
    always_comb begin
        cs_n     = (state == ST_GAP);
        sclk     = (state != ST_LOW);
        // sample point p: p=0 at GAP->HIGH, p=bidx+1 at LOW->HIGH
        shift_en = tick_done &&
                   ((state == ST_GAP) || (state == ST_LOW && bidx < KEEP_LAST));
        latch_en = tick_done && (state == ST_HIGH) && (bidx == BIT_LAST);
    end

endmodule

// File: rtl/sadc_shift_capture.sv
module sadc_shift_capture #(
    parameter int DATA_BITS = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sdata,
    input  logic                 shift_en,
    input  logic                 latch_en,
    output logic [DATA_BITS-1:0] sample,
    output logic                 sample_valid
);

    logic [DATA_BITS-1:0] sreg;

    // Leading points drop out of the top; only the last DATA_BITS kept points remain
    always_ff @(posedge clk) begin
        if (rst) begin
            sreg         <= '0;
            sample       <= '0;
            sample_valid <= 1'b0;
        end else begin
            if (shift_en)
                sreg <= {sreg[DATA_BITS-2:0], sdata};
            if (latch_en)
                sample <= sreg;
            sample_valid <= latch_en;
        end
    end

endmodule

// File: rtl/sadc_frame_capture.sv
module sadc_frame_capture #(
    parameter int HALF_CLKS   = 3,
    parameter int FRAME_SCLKS = 17,
    parameter int PERIOD_CLKS = 114,
    parameter int LEAD_BITS   = 4,
    parameter int DATA_BITS   = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 adc_sdata,
    output logic                 adc_cs_n,
    output logic                 adc_sclk,
    output logic [DATA_BITS-1:0] sample,
    output logic                 sample_valid
);

    localparam int ACTIVE_CLKS = FRAME_SCLKS * 2 * HALF_CLKS;
    localparam int GAP_CLKS    = PERIOD_CLKS - ACTIVE_CLKS;
    localparam int KEEP_POINTS = LEAD_BITS + DATA_BITS;

    logic shift_en;
    logic latch_en;

    sadc_frame_fsm #(
        .HALF_CLKS  (HALF_CLKS),
        .FRAME_SCLKS(FRAME_SCLKS),
        .GAP_CLKS   (GAP_CLKS),
        .KEEP_POINTS(KEEP_POINTS)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .cs_n    (adc_cs_n),
        .sclk    (adc_sclk),
        .shift_en(shift_en),
        .latch_en(latch_en)
    );

    sadc_shift_capture #(
        .DATA_BITS(DATA_BITS)
    ) u_capture (
        .clk         (clk),
        .rst         (rst),
        .sdata       (adc_sdata),
        .shift_en    (shift_en),
        .latch_en    (latch_en),
        .sample      (sample),
        .sample_valid(sample_valid)
    );

endmodule

// File: rtl/sadc_frame_capture_checker.sv
module sadc_frame_capture_checker #(
    parameter int HALF_CLKS   = 3,
    parameter int FRAME_SCLKS = 17,
    parameter int DATA_BITS   = 12
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 adc_cs_n,
    input logic                 adc_sclk,
    input logic [DATA_BITS-1:0] sample,
    input logic                 sample_valid
);

    localparam int ACTIVE_CLKS = FRAME_SCLKS * 2 * HALF_CLKS;
    localparam int CW          = $clog2(ACTIVE_CLKS + 2);

    logic [CW-1:0] low_cnt;
    logic [CW-1:0] hi_cnt;
    logic [CW-1:0] lo_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_cnt <= '0;
            hi_cnt  <= '0;
            lo_cnt  <= '0;
        end else begin
            low_cnt <= adc_cs_n ? '0 : low_cnt + 1'b1;
            hi_cnt  <= (adc_sclk && !adc_cs_n) ? hi_cnt + 1'b1 : '0;
            lo_cnt  <= (!adc_sclk) ? lo_cnt + 1'b1 : '0;
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (adc_cs_n && adc_sclk && !sample_valid && sample == '0));

    a_r2_high_half: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_sclk) |-> (hi_cnt == CW'(HALF_CLKS)));

    a_r2_low_half: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_sclk) |-> (lo_cnt == CW'(HALF_CLKS)));

    a_r3_low_length: assert property (@(posedge clk) disable iff (rst)
        $rose(adc_cs_n) |-> (low_cnt == CW'(ACTIVE_CLKS)));

    a_r4_gap_clock_high: assert property (@(posedge clk) disable iff (rst)
        adc_cs_n |-> adc_sclk);

    a_r5_cs_fall_on_high: assert property (@(posedge clk) disable iff (rst)
        $fell(adc_cs_n) |-> adc_sclk);

    a_r8_valid_place: assert property (@(posedge clk) disable iff (rst)
        sample_valid |-> (!adc_cs_n && !adc_sclk));

    a_r8_valid_single: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    a_r9_sample_hold: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |-> $stable(sample));

endmodule

bind sadc_frame_capture sadc_frame_capture_checker #(
    .HALF_CLKS  (HALF_CLKS),
    .FRAME_SCLKS(FRAME_SCLKS),
    .DATA_BITS  (DATA_BITS)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .adc_cs_n    (adc_cs_n),
    .adc_sclk    (adc_sclk),
    .sample      (sample),
    .sample_valid(sample_valid)
);

// File: tb/sadc_frame_capture_bench.sv
module sadc_frame_capture_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        adc_sdata;
    logic        adc_cs_n;
    logic        adc_sclk;
    logic [11:0] sample;
    logic        sample_valid;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    logic [11:0] cur_word = 12'h000;

    localparam int NV = 8;
    localparam logic [11:0] VEC [NV] = '{
        12'hA5A, 12'h000, 12'hFFF, 12'h800,
        12'h001, 12'h5A5, 12'h7FF, 12'h123
    };

    always #5 clk = ~clk;

    sadc_frame_capture u_sadc_frame_capture (
        .clk         (clk),
        .rst         (rst),
        .adc_sdata   (adc_sdata),
        .adc_cs_n    (adc_cs_n),
        .adc_sclk    (adc_sclk),
        .sample      (sample),
        .sample_valid(sample_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Converter model: points 4..15 carry the word MSB first, all others drive 1
    function automatic logic bitval(input logic [11:0] w, input int p);
        if (p >= 4 && p <= 15) return w[15-p];
        return 1'b1;
    endfunction

    // Converter model and timing monitor, sampled on the falling clock edge
    initial begin
        logic        prev_cs;
        logic        prev_sclk;
        logic [11:0] frame_word;
        logic [11:0] last_sample;
        int          low_idx;
        int          rises;
        int          since_fall;
        bit          seen_frame;
        prev_cs = 1'b1; prev_sclk = 1'b1; frame_word = '0; last_sample = '0;
        low_idx = 0; rises = 0; since_fall = 0; seen_frame = 1'b0;
        adc_sdata = 1'b1;
        forever begin
            @(negedge clk);
            if (rst) begin
                prev_cs = 1'b1; prev_sclk = 1'b1; seen_frame = 1'b0;
                since_fall = 0; low_idx = 0; rises = 0;
                last_sample = '0;
                adc_sdata = 1'b1;
            end else begin
                since_fall++;
                if (!adc_cs_n && prev_cs) begin
                    check(adc_sclk == 1'b1, "R5 sclk at cs fall", int'(adc_sclk), 1);
                    if (seen_frame)
                        check(since_fall == 114, "R4 frame spacing", since_fall, 114);
                    since_fall = 0; seen_frame = 1'b1;
                    low_idx = 0; rises = 0;
                    frame_word = cur_word;
                    adc_sdata = bitval(frame_word, 1);
                end else if (!adc_cs_n) begin
                    low_idx++;
                    if (adc_sclk && !prev_sclk) begin
                        rises++;
                        check(low_idx == 6 * rises, "R2 rising edge index", low_idx, 6 * rises);
                        adc_sdata = bitval(frame_word, rises + 1);
                    end
                    if (!adc_sclk && prev_sclk)
                        check(low_idx == 6 * rises + 3, "R2 falling edge index", low_idx, 6 * rises + 3);
                end
                if (adc_cs_n && !prev_cs) begin
                    check(low_idx + 1 == 102, "R3 cs low length", low_idx + 1, 102);
                    check(rises == 16, "R5 rising edges per frame", rises, 16);
                    adc_sdata = 1'b1;
                end
                if (adc_cs_n)
                    check(adc_sclk == 1'b1, "R4 sclk high in gap", int'(adc_sclk), 1);
                if (sample_valid)
                    check(!adc_cs_n && low_idx == 99, "R8 valid position", low_idx, 99);
                else
                    check(sample == last_sample, "R9 sample hold", int'(sample), int'(last_sample));
                last_sample = sample;
                prev_cs   = adc_cs_n;
                prev_sclk = adc_sclk;
            end
        end
    end

    task automatic wait_valid_and_check(input logic [11:0] exp, input string req);
        int width;
        do @(negedge clk); while (!sample_valid);
        check(sample == exp, req, int'(sample), int'(exp));
        width = 0;
        while (sample_valid) begin
            width++;
            @(negedge clk);
        end
        check(width == 1, "R8 valid width", width, 1);
    endtask

    task automatic release_and_time_first_frame();
        int n;
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (adc_cs_n && n < 50);
        check(n == 12, "R3 first frame after reset", n, 12);
    endtask

    initial begin
        cur_word = VEC[0];
        repeat (4) @(negedge clk);
        check(adc_cs_n == 1'b1, "R1 cs_n in reset", int'(adc_cs_n), 1);
        check(adc_sclk == 1'b1, "R1 sclk in reset", int'(adc_sclk), 1);
        check(sample == 12'h000, "R1 sample in reset", int'(sample), 0);
        check(sample_valid == 1'b0, "R1 valid in reset", int'(sample_valid), 0);

        release_and_time_first_frame();

        // Vector table walk: each frame returns one word (R6; 12'h000 also exercises R7)
        for (int i = 0; i < NV; i++) begin
            wait_valid_and_check(VEC[i], (VEC[i] == 12'h000) ? "R7 ignored points" : "R6 data word");
            if (i + 1 < NV) cur_word = VEC[i + 1];
        end

        // Reset in the middle of a frame (R1)
        cur_word = 12'hC3C;
        repeat (40) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(adc_cs_n == 1'b1, "R1 cs_n after mid-frame reset", int'(adc_cs_n), 1);
        check(adc_sclk == 1'b1, "R1 sclk after mid-frame reset", int'(adc_sclk), 1);
        check(sample == 12'h000, "R1 sample cleared", int'(sample), 0);
        check(sample_valid == 1'b0, "R1 valid after reset", int'(sample_valid), 0);

        release_and_time_first_frame();
        wait_valid_and_check(12'hC3C, "R6 word after reset");
        cur_word = 12'hFFF;
        wait_valid_and_check(12'hFFF, "R6 full scale");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule